// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM with a 16-bit data bus and active-low controls. The host offers one request at a time on a request/ready handshake. Each request carries an address, write data, a per-byte mask and a read/write select. The controller turns the request into a sequence of chip enable, output enable, write enable and byte enable levels. It holds each level for a parameterised number of clock cycles so that the memory's access, pulse-width and setup rules are met. Read data returns to the host with a one-cycle valid strobe. Byte lanes that the mask leaves out read as zero.

A write is the overlap of chip enable, write enable and at least one byte enable. The write ends when the byte enables rise, and write enable stays low through a recovery window. A further write accepted in the last recovery cycle keeps write enable low, so consecutive words are framed by the byte enables alone. A write that follows a read first passes through a turnaround window with every strobe high and the bus undriven. A request whose mask is all zeros is a one-cycle no-operation.

The states are `ST_IDLE`, `ST_NOP`, `ST_READ`, `ST_TURN`, `ST_WPULSE` and `ST_WREC`. The transitions are:
- IDLE to NOP, READ, TURN or WPULSE when a request is accepted. The choice depends on the mask, the select, and whether the last completed access was a read.
- NOP to IDLE after one cycle.
- READ to IDLE when the access count expires, with data captured on that edge.
- TURN to WPULSE when the turnaround count expires.
- WPULSE to WREC when the pulse count expires.
- WREC, when its count expires, to IDLE, or directly to NOP, READ or WPULSE if a request is accepted in that cycle.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, ready is 1, rsp_valid is 0, mem_dq_oe is 0, and mem_ce_n, mem_oe_n, mem_we_n and every mem_be_n bit are 1.
- R2: A read with a nonzero mask holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly T_ACC cycles. Bit i of mem_be_n is 0 exactly when mask bit i is 1; bit 0 is the lower byte (data bits 7:0) and bit 1 the upper byte. mem_din is captured on the last edge of that window, and unselected byte lanes of rsp_data are zero.
- R3: A write with a nonzero mask has an overlap of exactly T_WP cycles. During the overlap mem_ce_n=0, mem_we_n=0, the selected mem_be_n bits are 0 and mem_dout carries the write data. It is followed by T_REC recovery cycles with all mem_be_n bits 1 while mem_ce_n and mem_we_n stay 0 and the bus stays driven.
- R4: mem_oe_n and mem_we_n are never 0 together, and mem_dq_oe is 1 only while mem_we_n is 0.
- R5: A write whose previous non-empty access was a read is preceded by at least T_TURN+1 cycles with all strobes high and the bus undriven before mem_we_n falls.
- R6: A write accepted in the last recovery cycle of a write keeps mem_we_n low throughout, so one write-enable fall frames several words.
- R7: A request is taken only on a cycle where ready is 1, and ready is 0 in the following cycle. After acceptance ready stays 0 for T_ACC cycles on a read. On a write it stays 0 for T_WP+T_REC-1 cycles, plus T_TURN when a turnaround is needed. On an all-zero mask it stays 0 for 1 cycle.
- R8: An all-zero mask asserts no strobe, does not drive the bus and produces no rsp_valid.
- R9: rsp_valid is a single-cycle pulse in the cycle after a read capture, exactly one per non-empty read, and it coincides with ready returning to 1.
- R10: mem_addr does not change between two consecutive cycles in which some mem_be_n bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | DW/8 | Byte lane select, bit 0 = lower byte |
| ready | output | 1 | Controller can take a request this cycle |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DW | Read data, unselected lanes zero |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Data driven to the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_din | input | DW | Data returned by the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DW/8 | Byte enables, active low |

## Verification
The hardest situation to reach from the ports is a chained write burst. It needs a write request waiting in exactly the last recovery cycle, and the transition it exercises is invisible unless write enable is watched across word boundaries. The stimulus issues each request on the first cycle ready is high, with a random gap that is zero most of the time. Random write streams therefore land in the recovery cycle often. A directed run of three writes counts the write-enable falls against the byte-enable falls. A directed read followed at once by a write hits the minimum turnaround spacing.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_NOP    = 3'd1,
        ST_READ   = 3'd2,
        ST_TURN   = 3'd3,
        ST_WPULSE = 3'd4,
        ST_WREC   = 3'd5
    } ctl_state_t;

    // Strobe levels produced by the state decode, before lane masking.
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic lanes_on;
        logic drive;
    } strobe_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // A state loaded with N-1 lasts N cycles.
    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int T_ACC  = 3,
    parameter int T_WP   = 2,
    parameter int T_REC  = 1,
    parameter int T_TURN = 1,
    parameter int CW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic          req_zero,
    input  logic          tmr_done,
    output logic          ready,
    output logic          accept,
    output logic          capture,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output strobe_t       strb
);

    localparam logic [CW-1:0] LD_ACC  = CW'(T_ACC - 1);
    localparam logic [CW-1:0] LD_WP   = CW'(T_WP - 1);
    localparam logic [CW-1:0] LD_REC  = CW'(T_REC - 1);
    localparam logic [CW-1:0] LD_TURN = CW'(T_TURN - 1);

    ctl_state_t    state_q, state_d;
    logic          after_rd_q;
    ctl_state_t    route_st;
    logic [CW-1:0] route_val;

    // State register and the read-history flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            after_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                after_rd_q <= 1'b1;
            end else if (accept && req_we && !req_zero) begin
                after_rd_q <= 1'b0;
            end
        end
    end

    // Destination of a freshly accepted request.
    always_comb begin
        route_st  = ST_NOP;
        route_val = '0;
        if (req_zero) begin
            route_st  = ST_NOP;
            route_val = '0;
        end else if (!req_we) begin
            route_st  = ST_READ;
            route_val = LD_ACC;
        end else if (after_rd_q) begin
            route_st  = ST_TURN;
            route_val = LD_TURN;
        end else begin
            route_st  = ST_WPULSE;
            route_val = LD_WP;
        end
    end

    // Ready only where the current cycle-time count has run out.
    assign ready  = (state_q == ST_IDLE) || ((state_q == ST_WREC) && tmr_done);
    assign accept = ready && req;

    // Next state.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d  = route_st;
                    tmr_load = 1'b1;
                    tmr_val  = route_val;
                end
            end
            ST_NOP: begin
                state_d = ST_IDLE;
            end
            ST_READ: begin
                if (tmr_done) begin
                    capture = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    state_d  = ST_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WP;
                end
            end
            ST_WPULSE: begin
                if (tmr_done) begin
                    state_d  = ST_WREC;
                    tmr_load = 1'b1;
                    tmr_val  = LD_REC;
                end
            end
            ST_WREC: begin
                if (tmr_done) begin
                    if (req) begin
                        state_d  = route_st;
                        tmr_load = 1'b1;
                        tmr_val  = route_val;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Strobe levels, decoded from the registered state only.
    always_comb begin
        strb = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, lanes_on: 1'b0, drive: 1'b0};
        unique case (state_q)
            ST_IDLE, ST_NOP, ST_TURN: begin
                strb = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, lanes_on: 1'b0, drive: 1'b0};
            end
            ST_READ: begin
                strb = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, lanes_on: 1'b1, drive: 1'b0};
            end
            ST_WPULSE: begin
                strb = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, lanes_on: 1'b1, drive: 1'b1};
            end
            ST_WREC: begin
                strb = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, lanes_on: 1'b0, drive: 1'b1};
            end
            default: begin
                strb = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, lanes_on: 1'b0, drive: 1'b0};
            end
        endcase
    end

endmodule

// File: rtl/sram_ctl_path.sv
module sram_ctl_path #(
    parameter int AW = 17,
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [NB-1:0] req_mask,
    input  logic          capture,
    input  logic          lanes_on,
    input  logic [DW-1:0] mem_din,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [NB-1:0] be_n,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_valid
);

    logic [NB-1:0] mask_q;
    logic [DW-1:0] lane_bits;

    // Request fields are held for the whole access.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_bits[i*8 +: 8] = {8{mask_q[i]}};
        assign be_n[i]             = ~(mask_q[i] & lanes_on);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data  <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_data <= mem_din & lane_bits;
            end
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW     = 17,
    parameter int DW     = 16,
    parameter int T_ACC  = 3,
    parameter int T_WP   = 2,
    parameter int T_REC  = 1,
    parameter int T_TURN = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                req_we,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    input  logic [DW/8-1:0]     req_mask,
    output logic                ready,
    output logic                rsp_valid,
    output logic [DW-1:0]       rsp_data,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_dout,
    output logic                mem_dq_oe,
    input  logic [DW-1:0]       mem_din,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [DW/8-1:0]     mem_be_n
);

    localparam int NB   = DW / 8;
    localparam int TMAX = max_of4(T_ACC, T_WP, T_REC, T_TURN);
    localparam int CW   = (TMAX > 1) ? $clog2(TMAX) : 1;

    logic          accept;
    logic          capture;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    strobe_t       strb;

    sram_ctl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctl_fsm #(
        .T_ACC  (T_ACC),
        .T_WP   (T_WP),
        .T_REC  (T_REC),
        .T_TURN (T_TURN),
        .CW     (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_we   (req_we),
        .req_zero (req_mask == '0),
        .tmr_done (tmr_done),
        .ready    (ready),
        .accept   (accept),
        .capture  (capture),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .strb     (strb)
    );

    sram_ctl_path #(.AW(AW), .DW(DW), .NB(NB)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .capture   (capture),
        .lanes_on  (strb.lanes_on),
        .mem_din   (mem_din),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dout),
        .be_n      (mem_be_n),
        .rsp_data  (rsp_data),
        .rsp_valid (rsp_valid)
    );

    assign mem_ce_n  = strb.ce_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;
    assign mem_dq_oe = strb.drive;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int AW = 17,
    parameter int NB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          ready,
    input logic [NB-1:0] req_mask,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [NB-1:0] mem_be_n,
    input logic          mem_dq_oe,
    input logic          rsp_valid
);

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_drive_under_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    assert_ce_framing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> !mem_ce_n);

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_oe_n) && !$past(mem_dq_oe)));

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    assert_nop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && (req_mask == '0)) |=>
        (mem_ce_n && mem_oe_n && mem_we_n && (&mem_be_n) && !mem_dq_oe));

    assert_rvalid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rvalid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_be_n != '1) && $past(mem_be_n != '1)) |-> $stable(mem_addr));

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .NB(NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .ready     (ready),
    .req_mask  (req_mask),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;

    localparam int AW     = 17;
    localparam int DW     = 16;
    localparam int T_ACC  = 3;
    localparam int T_WP   = 2;
    localparam int T_REC  = 1;
    localparam int T_TURN = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
    logic [DW-1:0] rsp_data, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_be_n;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    sram_ctl #(
        .AW(AW), .DW(DW), .T_ACC(T_ACC), .T_WP(T_WP), .T_REC(T_REC), .T_TURN(T_TURN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .ready(ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe),
        .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'(i * 257) ^ 16'h3C3C;
    endfunction

    // Memory model: lanes not enabled read as 5A.
    logic [15:0] mem [0:255];
    logic [15:0] exp_mem [0:255];
    logic [15:0] row;

    always_comb begin
        row     = mem[mem_addr[7:0]];
        mem_din = 16'h5A5A;
        if (!mem_ce_n && !mem_oe_n) begin
            if (!mem_be_n[0]) mem_din[7:0]  = row[7:0];
            if (!mem_be_n[1]) mem_din[15:8] = row[15:8];
        end
    end

    always @(negedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_be_n[0]) mem[mem_addr[7:0]][7:0]  <= mem_dout[7:0];
            if (!mem_be_n[1]) mem[mem_addr[7:0]][15:8] <= mem_dout[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor of the memory side, sampled mid-cycle.
    int ovl_len = 0, rd_len = 0, idle_hi = 0, we_falls = 0, be_falls = 0, rv_cnt = 0;
    bit saw_rd = 0;
    logic          prev_we = 1'b1;
    logic [1:0]    prev_be = 2'b11;
    logic [AW-1:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(!((!mem_oe_n && !mem_we_n) || (mem_dq_oe && mem_we_n)), "R4 bus contention",
                {mem_oe_n, mem_we_n, mem_dq_oe}, 32'h0);
            if (!mem_ce_n && !mem_we_n && mem_be_n != 2'b11) begin
                ovl_len++;
            end else if (ovl_len > 0) begin
                chk(ovl_len == T_WP, "R3 write overlap length", ovl_len, T_WP);
                ovl_len = 0;
            end
            if (!mem_we_n && mem_be_n == 2'b11)
                chk(mem_dq_oe && !mem_ce_n, "R3 recovery hold", {mem_dq_oe, mem_ce_n}, 32'h2);
            if (!mem_oe_n) begin
                rd_len++;
            end else if (rd_len > 0) begin
                chk(rd_len == T_ACC, "R2 read access length", rd_len, T_ACC);
                rd_len = 0;
            end
            if (mem_be_n != 2'b11 && prev_be != 2'b11)
                chk(mem_addr == prev_addr, "R10 address hold", mem_addr, prev_addr);
            if (prev_we && !mem_we_n) begin
                we_falls++;
                if (saw_rd) chk(idle_hi >= T_TURN + 1, "R5 turnaround gap", idle_hi, T_TURN + 1);
                saw_rd = 0;
            end
            if (!mem_oe_n) saw_rd = 1;
            if (prev_be == 2'b11 && mem_be_n != 2'b11) be_falls++;
            if (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe) idle_hi++;
            else idle_hi = 0;
            if (rsp_valid) rv_cnt++;
            prev_we   = mem_we_n;
            prev_be   = mem_be_n;
            prev_addr = mem_addr;
        end
    end

    bit prev_rd = 0;
    int reads_done = 0;

    function automatic int exp_busy(input bit we, input logic [1:0] m, input bit after_rd);
        if (m == 2'b00) return 1;
        if (!we) return T_ACC;
        return (after_rd ? T_TURN : 0) + T_WP + T_REC - 1;
    endfunction

    function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input logic [1:0] m);
        logic [15:0] v;
        v = exp_mem[a[7:0]];
        return v & {{8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [15:0] d,
                         input logic [1:0] m, input int gap);
        int busy, eb;
        repeat (gap) @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
        eb = exp_busy(we, m, prev_rd);
        @(negedge clk);
        req = 1'b0;
        chk(!ready, "R7 ready drops after accept", ready, 0);
        if (m == 2'b00)
            chk(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe,
                "R8 no strobe on empty mask", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}, 32'h3E);
        busy = 0;
        while (!ready) begin busy++; @(negedge clk); end
        chk(busy == eb, "R7 busy length", busy, eb);
        if (!we && m != 2'b00) begin
            chk(rsp_valid, "R9 valid with ready", rsp_valid, 1);
            chk(rsp_data == exp_read(a, m), "R2 read data", rsp_data, exp_read(a, m));
            reads_done++;
            prev_rd = 1;
        end else begin
            chk(!rsp_valid, "R8 no response", rsp_valid, 0);
        end
        if (we && m != 2'b00) begin
            if (m[0]) exp_mem[a[7:0]][7:0]  = d[7:0];
            if (m[1]) exp_mem[a[7:0]][15:8] = d[15:8];
            prev_rd = 0;
        end
    endtask

    initial begin
        int wf0, bf0;
        for (int i = 0; i < 256; i++) begin
            mem[i]     <= init_val(i);
            exp_mem[i]  = init_val(i);
        end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(ready && !rsp_valid && !mem_dq_oe && mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11,
            "R1 reset state", {ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 32'h9F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && mem_ce_n && mem_we_n && !mem_dq_oe, "R1 after release",
            {ready, mem_ce_n, mem_we_n, mem_dq_oe}, 32'hE);

        // Directed: full-word write, single-lane reads, read then write at once.
        do_op(1, 17'h00010, 16'hBEEF, 2'b11, 0);
        do_op(0, 17'h00010, 16'h0000, 2'b01, 0);
        do_op(0, 17'h00010, 16'h0000, 2'b10, 0);
        do_op(1, 17'h00011, 16'h1234, 2'b10, 0);   // R5: turnaround right after read
        do_op(0, 17'h00011, 16'h0000, 2'b11, 0);
        do_op(0, 17'h00012, 16'h0000, 2'b00, 0);   // R8: empty read
        do_op(1, 17'h00012, 16'hFFFF, 2'b00, 0);   // R8: empty write
        do_op(0, 17'h00012, 16'h0000, 2'b11, 0);

        // Directed burst: three chained writes, R6.
        do_op(0, 17'h00000, 16'h0000, 2'b00, 2);
        wf0 = we_falls; bf0 = be_falls;
        do_op(1, 17'h00020, 16'h1111, 2'b11, 0);
        do_op(1, 17'h00021, 16'h2222, 2'b01, 0);
        do_op(1, 17'h00022, 16'h3333, 2'b10, 0);
        repeat (3) @(negedge clk);
        chk(we_falls - wf0 == 1, "R6 single write-enable fall", we_falls - wf0, 1);
        chk(be_falls - bf0 == 3, "R6 byte-enable frames", be_falls - bf0, 3);
        do_op(0, 17'h00021, 16'h0000, 2'b11, 0);

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            bit w;
            logic [AW-1:0] a;
            int g;
            w = 1'($urandom_range(0, 1));
            a = AW'($urandom_range(0, 255)) | (AW'($urandom_range(0, 511)) << 8);
            g = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 2) : 0;
            do_op(w, a, 16'($urandom), 2'($urandom_range(0, 3)), g);
        end

        repeat (4) @(negedge clk);
        chk(rv_cnt == reads_done, "R9 one valid per read", rv_cnt, reads_done);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule